// File: doc/BRIEF.md
# Key Event Queue with Overflow Lock

This block buffers key press and release events for a keypad controller. Each event is a 7-bit key code plus a state bit, and it is stored as one byte in a 16-entry circular queue. The queue is tracked by a head pointer and a 5-bit occupancy count. When an event is accepted, the block pulses a keypad-event request. When an event arrives with the queue already full, the block drops the event and pulses an overflow-error request. The interrupt and error registers that those pulses set are held outside this block.

The consumer reads in one of two ways. A consuming read first moves the head forward and then returns the entry at the new head. A peek read returns the entry at a chosen offset from the head and changes nothing. The surrounding logic drives a lock input while its error flag and overflow bit are both set. While the lock is high, incoming events are discarded without any response. A flush input empties the queue.

Top module: `key_event_queue`

## Requirements
- R1: While reset is held and in the cycle after it is released, `count_o` is 0, `rd_data_o` is 0x00, and both strobes are low.
- R2: An accepted push stores the byte {state, code} (state in bit 7, code in bits 6:0) at index (head + count) mod 16. After the clock edge, `count_o` is one higher and `kpd_set_o` is high for exactly one cycle.
- R3: A push that arrives when the count is already 16 is dropped. The count does not change from that push, `kpd_set_o` stays low, and `ovf_set_o` is high for one cycle. The count never exceeds 16.
- R4: While `lock_i` is high, a push is ignored. It stores nothing, changes no count, and raises neither strobe.
- R5: A consuming read issued while the count is 0 or 1 returns 0x00 on `rd_data_o` in the next cycle and leaves the head and count unchanged.
- R6: A consuming read issued while the count is 2 or more advances the head by one and lowers the count by one. In the next cycle it returns the entry at the new head.
- R7: A peek with offset k returns the entry at (head + k) mod 16 if k is less than the count, and 0x00 otherwise. A peek never changes the head or the count. A peek is ignored in any cycle that also has a consuming read.
- R8: A flush sets the head and the count to 0. It takes priority over a push and a read in the same cycle: the push is neither stored nor strobed, and `rd_data_o` reads 0x00.
- R9: A push and a consuming read in the same cycle change the count by the net amount. The pushed byte is written behind the tail that existed before the read.
- R10: All index arithmetic wraps modulo 16. Events written across the end of the storage are returned in order.
- R11: `rd_data_o` is 0x00 in any cycle that follows a cycle with no read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Empty the queue |
| push_i | input | 1 | Key event present this cycle |
| push_code_i | input | 7 | Key code of the event |
| push_state_i | input | 1 | Press/release state of the event |
| lock_i | input | 1 | Overflow error pending outside; refuse events |
| pop_i | input | 1 | Consuming read request |
| peek_i | input | 1 | Non-consuming read request |
| peek_off_i | input | 4 | Offset from head for a peek |
| rd_data_o | output | 8 | Read result, one cycle after the request |
| count_o | output | 5 | Number of stored events, 0 to 16 |
| kpd_set_o | output | 1 | One-cycle strobe: event accepted |
| ovf_set_o | output | 1 | One-cycle strobe: event dropped on full queue |

## Verification
A wrong head pointer or a wrong count shows up at the ports quickly. The next read returns a byte that differs from the stored history, and `count_o` differs in the cycle right after the faulty update. A wrong full test shows up as a strobe that is missing or extra on the push that meets a full queue. The bench therefore compares every output against a behavioural queue model on every clock, so a fault is reported in the first cycle where it becomes visible. Stimulus covers wrap across index 15, simultaneous push and read, flush with colliding requests, and pushes under lock.

// File: rtl/kq_pkg.sv
package kq_pkg;
    localparam int KQ_DEPTH_LOG2 = 4;
    localparam int KQ_CODE_W     = 7;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_POP  = 2'd1,
        SRC_PEEK = 2'd2
    } rd_src_e;
endpackage

// File: rtl/kq_store.sv
module kq_store #(
    parameter int IDX_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [IDX_W-1:0]  ra_idx_i,
    input  logic [IDX_W-1:0]  rb_idx_i,
    output logic [DATA_W-1:0] ra_data_o,
    output logic [DATA_W-1:0] rb_data_o
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] ent [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic [DATA_W-1:0] ent_q;
        always_ff @(posedge clk) begin
            if (wr_en_i && wr_idx_i == IDX_W'(i)) begin
                ent_q <= wr_data_i;
            end
        end
        assign ent[i] = ent_q;
    end

    assign ra_data_o = ent[ra_idx_i];
    assign rb_data_o = ent[rb_idx_i];
endmodule

// File: rtl/kq_ctrl.sv
module kq_ctrl
    import kq_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic             push_i,
    input  logic             lock_i,
    input  logic             pop_i,
    input  logic             peek_i,
    input  logic [IDX_W-1:0] peek_off_i,
    output logic             wr_en_o,
    output logic [IDX_W-1:0] wr_idx_o,
    output logic [IDX_W-1:0] pop_idx_o,
    output logic [IDX_W-1:0] peek_idx_o,
    output rd_src_e          rd_src_o,
    output logic [IDX_W:0]   cnt_o,
    output logic             kpd_set_o,
    output logic             ovf_set_o
);
    localparam int          DEPTH    = 1 << IDX_W;
    localparam logic [IDX_W:0] FULL_CNT = (IDX_W+1)'(DEPTH);

    typedef struct packed {
        logic [IDX_W-1:0] head;
        logic [IDX_W:0]   cnt;
        logic             kpd;
        logic             ovf;
    } ctrl_t;

    ctrl_t st_q, st_d;
    logic  pop_go, push_try, push_go;

    always_comb begin
        st_d     = st_q;
        st_d.kpd = 1'b0;
        st_d.ovf = 1'b0;
        pop_go   = pop_i && !flush_i && (st_q.cnt > (IDX_W+1)'(1));
        push_try = push_i && !flush_i && !lock_i;
        push_go  = push_try && (st_q.cnt != FULL_CNT);
        rd_src_o = SRC_NONE;
        if (pop_go) begin
            rd_src_o = SRC_POP;
        end else if (peek_i && !pop_i && !flush_i && ({1'b0, peek_off_i} < st_q.cnt)) begin
            rd_src_o = SRC_PEEK;
        end
        if (flush_i) begin
            st_d.head = '0;
            st_d.cnt  = '0;
        end else begin
            if (pop_go) begin
                st_d.head = st_q.head + IDX_W'(1);
            end
            st_d.cnt = st_q.cnt + (IDX_W+1)'(push_go) - (IDX_W+1)'(pop_go);
            st_d.kpd = push_go;
            st_d.ovf = push_try && !push_go;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_en_o    = push_go;
    assign wr_idx_o   = st_q.head + st_q.cnt[IDX_W-1:0];
    assign pop_idx_o  = st_q.head + IDX_W'(1);
    assign peek_idx_o = st_q.head + peek_off_i;
    assign cnt_o      = st_q.cnt;
    assign kpd_set_o  = st_q.kpd;
    assign ovf_set_o  = st_q.ovf;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= FULL_CNT); // R3
    AST_OVF_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ovf |-> $past(st_q.cnt) == FULL_CNT); // R3
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({st_q.kpd, st_q.ovf})); // R2
    AST_LOCK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_i && push_i && !pop_i && !flush_i) |=> (!st_q.kpd && !st_q.ovf && $stable(st_q.cnt))); // R4
    AST_SHORT_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && !flush_i && st_q.cnt <= (IDX_W+1)'(1)) |=> ($stable(st_q.cnt) && $stable(st_q.head))); // R5
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (st_q.cnt == '0 && !st_q.kpd)); // R8
endmodule

// File: rtl/key_event_queue.sv
module key_event_queue
    import kq_pkg::*;
#(
    parameter int IDX_W  = KQ_DEPTH_LOG2,
    parameter int CODE_W = KQ_CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              push_i,
    input  logic [CODE_W-1:0] push_code_i,
    input  logic              push_state_i,
    input  logic              lock_i,
    input  logic              pop_i,
    input  logic              peek_i,
    input  logic [IDX_W-1:0]  peek_off_i,
    output logic [CODE_W:0]   rd_data_o,
    output logic [IDX_W:0]    count_o,
    output logic              kpd_set_o,
    output logic              ovf_set_o
);
    localparam int DATA_W = CODE_W + 1;

    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx, pop_idx, peek_idx;
    logic [DATA_W-1:0] pop_data, peek_data;
    rd_src_e           rd_src;
    logic [DATA_W-1:0] rd_d, rd_q;

    kq_ctrl #(.IDX_W(IDX_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush_i    (flush_i),
        .push_i     (push_i),
        .lock_i     (lock_i),
        .pop_i      (pop_i),
        .peek_i     (peek_i),
        .peek_off_i (peek_off_i),
        .wr_en_o    (wr_en),
        .wr_idx_o   (wr_idx),
        .pop_idx_o  (pop_idx),
        .peek_idx_o (peek_idx),
        .rd_src_o   (rd_src),
        .cnt_o      (count_o),
        .kpd_set_o  (kpd_set_o),
        .ovf_set_o  (ovf_set_o)
    );

    kq_store #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_store (
        .clk       (clk),
        .wr_en_i   (wr_en),
        .wr_idx_i  (wr_idx),
        .wr_data_i ({push_state_i, push_code_i}),
        .ra_idx_i  (pop_idx),
        .rb_idx_i  (peek_idx),
        .ra_data_o (pop_data),
        .rb_data_o (peek_data)
    );

    always_comb begin
        case (rd_src)
            SRC_POP:  rd_d = pop_data;
            SRC_PEEK: rd_d = peek_data;
            default:  rd_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_data_o = rd_q;

    AST_PEEK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (peek_i && !pop_i && !flush_i && {1'b0, peek_off_i} >= count_o) |=> (rd_data_o == '0)); // R7
    AST_SHORT_POP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !flush_i && count_o <= (IDX_W+1)'(1)) |=> (rd_data_o == '0)); // R5
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!pop_i && !peek_i) |=> (rd_data_o == '0)); // R11
endmodule

// File: tb/key_event_queue_tb.sv
module key_event_queue_tb;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       flush_i = 0, push_i = 0, push_state_i = 0, lock_i = 0, pop_i = 0, peek_i = 0;
    logic [6:0] push_code_i = '0;
    logic [3:0] peek_off_i = '0;
    logic [7:0] rd_data_o;
    logic [4:0] count_o;
    logic       kpd_set_o, ovf_set_o;

    int total = 0;
    int bad = 0;

    int mq [16];
    int ms = 0;
    int ml = 0;
    int e_rd = 0, e_k = 0, e_o = 0;

    always #(CLK_P/2) clk = ~clk;

    key_event_queue u_dut (
        .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .push_i(push_i),
        .push_code_i(push_code_i), .push_state_i(push_state_i), .lock_i(lock_i),
        .pop_i(pop_i), .peek_i(peek_i), .peek_off_i(peek_off_i),
        .rd_data_o(rd_data_o), .count_o(count_o), .kpd_set_o(kpd_set_o), .ovf_set_o(ovf_set_o)
    );

    task automatic chk(string tag, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic cmp_all(string tag);
        chk(tag, "count", count_o, ml);
        chk(tag, "rd_data", rd_data_o, e_rd);
        chk(tag, "kpd_set", kpd_set_o, e_k);
        chk(tag, "ovf_set", ovf_set_o, e_o);
    endtask

    // drive one cycle of inputs at negedge, advance the model, compare at the next negedge
    task automatic cyc(string tag, bit fl, bit ps, int code, bit stt, bit lk,
                       bit pp, bit pk, int off);
        bit pt, pg;
        flush_i = fl; push_i = ps; push_code_i = 7'(code); push_state_i = stt;
        lock_i = lk; pop_i = pp; peek_i = pk; peek_off_i = 4'(off);
        e_rd = 0; e_k = 0; e_o = 0;
        if (fl) begin
            ms = 0; ml = 0;
        end else begin
            pt = ps && !lk;
            pg = pp && (ml > 1);
            if (pg) e_rd = mq[(ms + 1) % 16];
            else if (pk && !pp && off < ml) e_rd = mq[(ms + off) % 16];
            if (pt && ml == 16) e_o = 1;
            else if (pt) begin
                mq[(ms + ml) % 16] = (int'(stt) << 7) | code;
                ml++;
                e_k = 1;
            end
            if (pg) begin
                ms = (ms + 1) % 16;
                ml--;
            end
        end
        @(posedge clk);
        @(negedge clk);
        cmp_all(tag);
    endtask

    task automatic idle(string tag);
        cyc(tag, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(CLK_P * 50000);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        cmp_all("R1");
        rst_n = 1'b1;
        idle("R1");
        // three events, then peek each, and one past the end
        cyc("R2", 0, 1, 7'h3c, 1, 0, 0, 0, 0);
        cyc("R2", 0, 1, 7'h11, 0, 0, 0, 0, 0);
        cyc("R2", 0, 1, 7'h55, 1, 0, 0, 0, 0);
        for (int k = 0; k < 4; k++) cyc("R7", 0, 0, 0, 0, 0, 0, 1, k);
        cyc("R7", 0, 0, 0, 0, 0, 0, 1, 15);
        // pop and peek together: pop wins
        cyc("R7", 0, 0, 0, 0, 0, 1, 1, 0);
        cyc("R6", 0, 0, 0, 0, 0, 1, 0, 0);
        cyc("R5", 0, 0, 0, 0, 0, 1, 0, 0);
        cyc("R5", 0, 0, 0, 0, 0, 1, 0, 0);
        cyc("R7", 0, 0, 0, 0, 0, 0, 1, 0);
        idle("R11");
        // fill across the wrap point to full
        for (int i = 0; i < 15; i++) cyc("R10", 0, 1, 7'h20 + i, i[0], 0, 0, 0, 0);
        cyc("R3", 0, 1, 7'h7f, 1, 0, 0, 0, 0);
        cyc("R3", 0, 1, 7'h01, 0, 0, 0, 0, 0);
        for (int k = 0; k < 16; k++) cyc("R10", 0, 0, 0, 0, 0, 0, 1, k);
        // lock refuses events even with room
        cyc("R6", 0, 0, 0, 0, 0, 1, 0, 0);
        cyc("R4", 0, 1, 7'h44, 1, 1, 0, 0, 0);
        cyc("R4", 0, 1, 7'h45, 0, 1, 0, 0, 0);
        // full queue: push while popping is still dropped
        cyc("R3", 0, 1, 7'h46, 0, 0, 0, 0, 0);
        cyc("R3", 0, 1, 7'h47, 1, 0, 1, 0, 0);
        // simultaneous push and pop
        for (int i = 0; i < 6; i++) cyc("R9", 0, 1, 7'h60 + i, 1, 0, 1, 0, 0);
        for (int i = 0; i < 14; i++) cyc("R10", 0, 0, 0, 0, 0, 1, 0, 0);
        cyc("R5", 0, 1, 7'h0a, 0, 0, 1, 0, 0);
        cyc("R9", 0, 1, 7'h0b, 1, 0, 1, 0, 0);
        // flush beats push and reads
        cyc("R8", 1, 1, 7'h12, 1, 0, 1, 1, 0);
        cyc("R8", 0, 0, 0, 0, 0, 0, 1, 0);
        cyc("R2", 0, 1, 7'h2b, 0, 0, 0, 0, 0);
        cyc("R2", 0, 1, 7'h2c, 1, 0, 0, 0, 0);
        cyc("R7", 0, 0, 0, 0, 0, 0, 1, 1);
        cyc("R8", 1, 0, 0, 0, 0, 0, 0, 0);
        cyc("R5", 0, 0, 0, 0, 0, 1, 0, 0);
        idle("R11");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule